// File: doc/BRIEF.md
# Stereo Serial Audio Sample Port (MSB-Justified, Slave)

This block joins a converter's parallel sample path to a three-wire serial audio link whose bit clock and frame clock come from an outside master. On the receive side it deserialises playback samples arriving on the serial input and hands a left/right pair to the core with a one-cycle strobe. On the transmit side it takes parallel capture samples for both channels and serialises them onto the serial output. The outgoing line can be held at the zero code by a qualifier from the control logic, for example while the converter is initialising or powered down.

Each sample is 16 bits, two's complement, most significant bit first. The most significant bit sits in the first bit slot after a frame-clock edge, with no one-bit delay. The left channel fills the half-frame in which the frame clock is high. A half-frame may be longer than 16 bit clocks, and the bits after the sixteenth are padding. The serial clocks are sampled by the block's system clock through a synchroniser of configurable depth, so the system clock must run several times faster than the bit clock.

Top module: `sap_serial_port`

## Requirements
- R1: During and right after reset, `sdo` is 0, `rx_valid` is 0 and `rx_left`/`rx_right` are 0x0000.
- R2: The first bit-clock rising edge after a frame-clock edge carries bit 15 of that half-frame's input word, and bits 14 down to 0 follow on the next rising edges. The half-frame with the frame clock high (1) is the left channel, and the half-frame with it low (0) is the right channel.
- R3: Input bits after the sixteenth of a half-frame have no effect on the received words.
- R4: A frame of exactly 32 bit clocks (16 per half-frame) is received and transmitted completely.
- R5: If either half-frame of a frame has fewer than 16 bit clocks, no pair is delivered for that frame, and the next complete frame is delivered normally.
- R6: Bit 15 of the outgoing word is on `sdo` before the first bit-clock rising edge of its half-frame. `sdo` advances to the next lower bit after each rising edge. Both outgoing words are taken from `tx_left`/`tx_right` at the start of the left half-frame, and later changes on those inputs do not affect that frame.
- R7: After the sixteenth bit of a half-frame, `sdo` is 0 until the next frame-clock edge.
- R8: While `force_zero` is 1, `sdo` is 0 from the following system-clock cycle on, so the far end reads the code 0x0000.
- R9: The full-scale codes 0x7FFF and 0x8000 and the mid-scale code 0x0000 pass through both directions unchanged.
- R10: A pair is delivered by a `rx_valid` pulse one system-clock cycle wide, after the sixteenth bit of the right half-frame. `rx_left`/`rx_right` change only together with that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run several times faster than `bclk` |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock from the link master |
| fclk | input | 1 | Frame clock; 1 = left half-frame, 0 = right half-frame |
| sdi | input | 1 | Serial playback data, sampled on `bclk` rising edges |
| sdo | output | 1 | Serial capture data, changes after `bclk` rising edges |
| force_zero | input | 1 | Holds `sdo` at 0 while 1 |
| tx_left | input | 16 | Left capture word to transmit |
| tx_right | input | 16 | Right capture word to transmit |
| rx_left | output | 16 | Last received left playback word |
| rx_right | output | 16 | Last received right playback word |
| rx_valid | output | 1 | One-cycle strobe: a new pair is on `rx_left`/`rx_right` |

## Verification
The bench targets frames at the 32-bit minimum and frames with padding that toggles against the data. A receiver that counted past bit 16 would corrupt words, and one with a one-bit MSB delay would shift every word by a bit. It truncates first a left and then a right half-frame. A design that paired stale halves would then emit a pair that matches no frame. It checks the padding slots and a `force_zero` frame bit by bit, where a missing tail clear or gate leaks data onto `sdo`. It also changes the transmit inputs in the middle of the frame, so a design that sampled the right word late would send the wrong right word.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SAMPLE_W = 16;
    localparam int SLOT_W   = $clog2(SAMPLE_W + 1);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [SLOT_W-1:0]   slot_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

    localparam slot_t SLOT_LAST = slot_t'(SAMPLE_W - 1);
    localparam slot_t SLOT_DONE = slot_t'(SAMPLE_W);

    function automatic chan_e chan_of(input logic frame_level);
        return frame_level ? CH_LEFT : CH_RIGHT;
    endfunction

    function automatic logic slot_active(input slot_t slot);
        return slot < SLOT_DONE;
    endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sap_events.sv
module sap_events
    import sap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bclk_s,
    input  logic  fclk_s,
    output logic  bit_rise,
    output logic  half_start,
    output chan_e half_chan
);

    logic bclk_d;
    logic fclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d <= 1'b0;
            fclk_d <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            fclk_d <= fclk_s;
        end
    end

    assign bit_rise   = bclk_s & ~bclk_d;
    assign half_start = fclk_s ^ fclk_d;
    assign half_chan  = chan_of(fclk_s);

endmodule

// File: rtl/sap_deser.sv
module sap_deser
    import sap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_rise,
    input  logic    half_start,
    input  chan_e   half_chan,
    input  logic    sdi_s,
    output stereo_t rx_pair,
    output logic    rx_strobe
);

    slot_t   slot;
    chan_e   cur_chan;
    sample_t shifter;
    sample_t left_hold;
    logic    left_ok;
    sample_t word_next;

    assign word_next = {shifter[SAMPLE_W-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= SLOT_DONE;
            cur_chan  <= CH_RIGHT;
            shifter   <= '0;
            left_hold <= '0;
            left_ok   <= 1'b0;
            rx_pair   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (half_start) begin
                slot     <= '0;
                cur_chan <= half_chan;
                if (half_chan == CH_LEFT) left_ok <= 1'b0;
            end else if (bit_rise && slot_active(slot)) begin
                shifter <= word_next;
                slot    <= slot + slot_t'(1);
                if (slot == SLOT_LAST) begin
                    if (cur_chan == CH_LEFT) begin
                        left_hold <= word_next;
                        left_ok   <= 1'b1;
                    end else if (left_ok) begin
                        rx_pair   <= '{left: left_hold, right: word_next};
                        rx_strobe <= 1'b1;
                        left_ok   <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sap_ser.sv
module sap_ser
    import sap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_rise,
    input  logic    half_start,
    input  chan_e   half_chan,
    input  logic    force_zero,
    input  stereo_t tx_pair,
    output logic    sdo,
    output logic    tail
);

    slot_t   slot;
    sample_t shifter;
    sample_t right_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot       <= SLOT_DONE;
            shifter    <= '0;
            right_hold <= '0;
        end else if (half_start) begin
            slot <= '0;
            if (half_chan == CH_LEFT) begin
                shifter    <= tx_pair.left;
                right_hold <= tx_pair.right;
            end else begin
                shifter    <= right_hold;
            end
        end else if (bit_rise && slot_active(slot)) begin
            shifter <= {shifter[SAMPLE_W-2:0], 1'b0};
            slot    <= slot + slot_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sdo <= 1'b0;
        else     sdo <= ~force_zero & slot_active(slot) & shifter[SAMPLE_W-1];
    end

    assign tail = ~slot_active(slot);

endmodule

// File: rtl/sap_serial_port.sv
module sap_serial_port
    import sap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk,
    input  logic                fclk,
    input  logic                sdi,
    output logic                sdo,
    input  logic                force_zero,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    localparam int LINE_W = 3;

    logic [LINE_W-1:0] line_s;
    logic              bit_rise;
    logic              half_start;
    chan_e             half_chan;
    stereo_t           rx_pair;
    stereo_t           tx_pair;
    logic              tx_tail;

    sap_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bclk, fclk, sdi}),
        .q   (line_s)
    );

    sap_events i_events (
        .clk        (clk),
        .rst        (rst),
        .bclk_s     (line_s[2]),
        .fclk_s     (line_s[1]),
        .bit_rise   (bit_rise),
        .half_start (half_start),
        .half_chan  (half_chan)
    );

    sap_deser i_deser (
        .clk        (clk),
        .rst        (rst),
        .bit_rise   (bit_rise),
        .half_start (half_start),
        .half_chan  (half_chan),
        .sdi_s      (line_s[0]),
        .rx_pair    (rx_pair),
        .rx_strobe  (rx_valid)
    );

    assign tx_pair = '{left: tx_left, right: tx_right};

    sap_ser i_ser (
        .clk        (clk),
        .rst        (rst),
        .bit_rise   (bit_rise),
        .half_start (half_start),
        .half_chan  (half_chan),
        .force_zero (force_zero),
        .tx_pair    (tx_pair),
        .sdo        (sdo),
        .tail       (tx_tail)
    );

    assign rx_left  = rx_pair.left;
    assign rx_right = rx_pair.right;

endmodule

// File: rtl/sap_serial_port_chk.sv
module sap_serial_port_chk
    import sap_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          force_zero,
    input logic          sdo,
    input logic          rx_valid,
    input logic [SAMPLE_W-1:0] rx_left,
    input logic [SAMPLE_W-1:0] rx_right,
    input logic          bit_rise,
    input logic          tx_tail
);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!rx_valid && !sdo));

    // R8
    a_r8_force_zero: assert property (@(posedge clk) disable iff (rst)
        force_zero |=> !sdo);

    // R7
    a_r7_tail_zero: assert property (@(posedge clk) disable iff (rst)
        tx_tail |=> !sdo);

    // R10
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10
    a_r10_words_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

    // R2
    a_r2_valid_after_bit: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bit_rise));

endmodule

bind sap_serial_port sap_serial_port_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .force_zero (force_zero),
    .sdo        (sdo),
    .rx_valid   (rx_valid),
    .rx_left    (rx_left),
    .rx_right   (rx_right),
    .bit_rise   (bit_rise),
    .tx_tail    (tx_tail)
);

// File: tb/test_sap_serial_port.sv
module test_sap_serial_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdi = 1'b0;
    logic        force_zero = 1'b0;
    logic [15:0] tx_left = '0;
    logic [15:0] tx_right = '0;
    logic        sdo;
    logic [15:0] rx_left;
    logic [15:0] rx_right;
    logic        rx_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    sap_serial_port i_sap_serial_port (
        .clk        (clk),
        .rst        (rst),
        .bclk       (bclk),
        .fclk       (fclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .force_zero (force_zero),
        .tx_left    (tx_left),
        .tx_right   (tx_right),
        .rx_left    (rx_left),
        .rx_right   (rx_right),
        .rx_valid   (rx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one half-frame: nbits bit clocks, frame clock at lvl
    task automatic drive_half(input bit lvl, input int nbits, input logic [15:0] in_word,
                              input logic [15:0] out_word, input string tag);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bclk = 1'b0;
            if (i == 0) fclk = lvl;
            sdi = (i < 16) ? in_word[15-i] : ~in_word[i % 16];
            repeat (HALF-1) @(negedge clk);
            if (force_zero)
                check(sdo === 1'b0, "R8 force", {15'd0, sdo}, 16'd0);
            else if (i < 16)
                check(sdo === out_word[15-i], tag, {15'd0, sdo}, {15'd0, out_word[15-i]});
            else
                check(sdo === 1'b0, "R7 tail", {15'd0, sdo}, 16'd0);
            @(negedge clk);
            bclk = 1'b1;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    task automatic send_frame(input int lbits, input int rbits,
                              input logic [15:0] in_l, input logic [15:0] in_r,
                              input logic [15:0] out_l, input logic [15:0] out_r,
                              input bit expect_pair, input string tag);
        tx_left  = out_l;
        tx_right = out_r;
        if (expect_pair) begin
            exp_q.push_back({in_l, in_r});
            tag_q.push_back(tag);
        end
        drive_half(1'b1, lbits, in_l, out_l, {tag, " R6 sdo left"});
        // R6: inputs changed after the left edge must not reach the wire
        tx_left  = ~out_l;
        tx_right = ~out_r;
        drive_half(1'b0, rbits, in_r, out_r, {tag, " R6 sdo right"});
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected pair", rx_left, 16'hxxxx);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rx_left === e[31:16], {t, " R2 left"}, rx_left, e[31:16]);
                    check(rx_right === e[15:0], {t, " R2 right"}, rx_right, e[15:0]);
                    @(negedge clk);
                    check(rx_valid === 1'b0, "R10 pulse width", {15'd0, rx_valid}, 16'd0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(sdo === 1'b0, "R1 sdo", {15'd0, sdo}, 16'd0);
        check(rx_valid === 1'b0, "R1 valid", {15'd0, rx_valid}, 16'd0);
        check(rx_left === 16'h0000, "R1 left", rx_left, 16'h0000);
        check(rx_right === 16'h0000, "R1 right", rx_right, 16'h0000);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R9 full-scale codes, 64-bit frame
        send_frame(32, 32, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 1'b1, "R9");
        // R4 minimum 32-bit frame
        send_frame(16, 16, 16'h8000, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, "R4");
        // R3 padding bits ignored, 48-bit frame
        send_frame(24, 24, 16'hA5A5, 16'h5A5A, 16'h1234, 16'hABCD, 1'b1, "R3");
        // R8 force zero on the output; receive unaffected
        force_zero = 1'b1;
        send_frame(20, 20, 16'hF00F, 16'h0FF0, 16'h1111, 16'h2222, 1'b1, "R8");
        force_zero = 1'b0;
        // R5 short left half-frame: no pair
        send_frame(10, 16, 16'hC3C3, 16'h3C3C, 16'h9876, 16'h4321, 1'b0, "R5");
        send_frame(32, 32, 16'h0000, 16'h0001, 16'h0F0F, 16'hF0F0, 1'b1, "R5 recovery");
        // R5 short right half-frame: no pair
        send_frame(16, 8, 16'h1357, 16'h2468, 16'h8001, 16'h7FFE, 1'b0, "R5");
        send_frame(20, 28, 16'hBEEF, 16'hCAFE, 16'h6DB6, 16'h0000, 1'b1, "R2");

        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R5 pending pairs", 16'(exp_q.size()), 16'd0);
        // R10 words held after last pulse
        check(rx_left === 16'hBEEF, "R10 hold left", rx_left, 16'hBEEF);
        check(rx_right === 16'hCAFE, "R10 hold right", rx_right, 16'hCAFE);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule